// File: doc/BRIEF.md
# Thermal Range Residency Evaluator

This block grades how well a thermal management controller has behaved across one observation window. On every tick with a valid sample it receives one reading per monitored quantity: a die temperature in whole degrees and an operating frequency level. Each reading is sorted into a low, middle or high band. Each quantity has its own lower and upper threshold. A saturating counter per band records how many ticks the reading spent there.

When the window closes, the block freezes the band counts and starts a fresh window. It then uses one shared sequential divider to work out a score for each band. The score compares the share of the window actually spent in that band with a programmed target share. A score of 1.0 means the target was met exactly. Below 1.0 means too little time was spent in the band, and above 1.0 means too much. Band scores are averaged for each quantity, and the per-quantity scores are added into one overall index. A perfect controller therefore scores an index equal to the number of monitored quantities. All results are unsigned Q8.8.

Top module: `resid_score_eval`

## Requirements
- R1: Quantity p is read from bits [p*8 +: 8] of `samples`; index 0 is temperature and index 1 is frequency level. A reading above `thr_hi` of its quantity is high (range code 2). A reading from `thr_lo` to `thr_hi` inclusive is middle (code 1). Anything below `thr_lo` is low (code 0). With thresholds 74 and 78, a temperature of 72 or 73 therefore counts as low.
- R2: Band j = p*3 + code has target share `desired_pct[j*7 +: 7]` in percent. Its score on `ratio_o[j*16 +: 16]` is floor(count*25600 / (window_ticks*desired)). Here window_ticks is the sum of the three counts of quantity p.
- R3: If the target share is zero or the window held no sample, the band score is 0 and `zero_flag[j]` is 1. Otherwise `zero_flag[j]` is 0.
- R4: The score of quantity p on `score_o[p*16 +: 16]` is floor of the sum of its three band scores divided by 3.
- R5: `total_o` is the sum of all quantity scores.
- R6: A band count holds at 2^CNT_W-1 instead of wrapping.
- R7: A `window_done` pulse closes the window. A sample presented in the same cycle belongs to the closing window. The next window starts from zero counts.
- R8: `res_valid` is high for exactly one cycle when all results of a window are ready. All result outputs keep their values until the next such pulse.
- R9: A `window_done` that arrives while results are still being computed is ignored. Counting carries on into the window that is already open.
- R10: After reset, `res_valid`, all band scores, flags, quantity scores and the total are 0.
- R11: Each quantity is classified with its own thresholds and scored independently, with no influence from the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Samples on this tick are valid |
| samples | input | NP*SAMP_W | One reading per quantity |
| thr_lo | input | NP*SAMP_W | Lower middle-band bound per quantity |
| thr_hi | input | NP*SAMP_W | Upper middle-band bound per quantity |
| desired_pct | input | NP*3*DES_W | Target share per band, percent |
| window_done | input | 1 | Closes the current window |
| res_valid | output | 1 | One-cycle pulse: results updated |
| ratio_o | output | NP*3*Q_W | Band scores, Q8.8 |
| zero_flag | output | NP*3 | Band score forced to zero |
| score_o | output | NP*Q_W | Quantity scores, Q8.8 |
| total_o | output | Q_W+clog2(NP) | Overall index, Q8.8 |

## Verification
The assertions assume that thresholds and target shares stay constant from the start of a window until its results are reported. They also assume that a target share never exceeds 100, so no band score goes past the Q8.8 range. The stimulus writes thresholds once after reset and changes target shares only between windows, always within 0 to 100. The assertions place no other limit on `window_done` or `sample_vld`, and the bench deliberately pulses `window_done` during a computation and together with a sample.

// File: rtl/resid_pkg.sv
package resid_pkg;
  localparam int NUM_RANGES = 3;
  localparam int Q_FRAC     = 8;
  localparam int PCT_FULL   = 100;

  typedef enum logic [1:0] {
    RNG_LOW  = 2'd0,
    RNG_MID  = 2'd1,
    RNG_HIGH = 2'd2
  } rng_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } seq_e;
endpackage

// File: rtl/resid_classify.sv
module resid_classify
  import resid_pkg::*;
#(
  parameter int SAMP_W = 8
) (
  input  logic [SAMP_W-1:0] sample,
  input  logic [SAMP_W-1:0] lo_thr,
  input  logic [SAMP_W-1:0] hi_thr,
  output logic [1:0]        rng
);
  rng_e band;

  // Anything under the lower bound, including a gap below it, is low.
  always_comb begin
    if (sample > hi_thr)       band = RNG_HIGH;
    else if (sample >= lo_thr) band = RNG_MID;
    else                       band = RNG_LOW;
  end

  assign rng = band;
endmodule

// File: rtl/resid_bank.sv
module resid_bank
  import resid_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inc,
  input  logic [1:0]                  rng,
  input  logic                        accept,
  output logic [NUM_RANGES*CNT_W-1:0] cnt_o,
  output logic [NUM_RANGES*CNT_W-1:0] snap_o
);
  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_band
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] nxt;
    logic             hit;

    assign hit = inc && (rng == 2'(r));
    assign nxt = (hit && (cnt_q != {CNT_W{1'b1}})) ? cnt_q + CNT_W'(1) : cnt_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        snap_q <= '0;
      end else if (accept) begin
        snap_q <= nxt;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= nxt;
      end
    end

    assign cnt_o[r*CNT_W +: CNT_W]  = cnt_q;
    assign snap_o[r*CNT_W +: CNT_W] = snap_q;
  end
endmodule

// File: rtl/resid_divider.sv
module resid_divider #(
  parameter int NW = 24,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;
  logic [DW:0]   trial;
  logic [DW-1:0] diff;
  logic          ge;

  assign trial = {rem_q, q_q[NW-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial[DW-1:0] - den_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q    <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        q_q   <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CW'(NW);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[NW-2:0], ge};
        rem_q <= ge ? diff : trial[DW-1:0];
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;
endmodule

// File: rtl/resid_score_eval.sv
module resid_score_eval
  import resid_pkg::*;
#(
  parameter int NP     = 2,
  parameter int SAMP_W = 8,
  parameter int CNT_W  = 16,
  parameter int DES_W  = 7,
  parameter int Q_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sample_vld,
  input  logic [NP*SAMP_W-1:0]           samples,
  input  logic [NP*SAMP_W-1:0]           thr_lo,
  input  logic [NP*SAMP_W-1:0]           thr_hi,
  input  logic [NP*NUM_RANGES*DES_W-1:0] desired_pct,
  input  logic                           window_done,
  output logic                           res_valid,
  output logic [NP*NUM_RANGES*Q_W-1:0]   ratio_o,
  output logic [NP*NUM_RANGES-1:0]       zero_flag,
  output logic [NP*Q_W-1:0]              score_o,
  output logic [Q_W+$clog2(NP)-1:0]      total_o
);
  localparam int NR      = NUM_RANGES;
  localparam int NRJ     = NP * NR;
  localparam int NJ      = NRJ + NP;
  localparam int JB      = $clog2(NJ);
  localparam int WIN_W   = CNT_W + $clog2(NR);
  localparam int SCALE   = PCT_FULL << Q_FRAC;
  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int RNUM_W  = CNT_W + SCALE_W;
  localparam int SUM_W   = Q_W + $clog2(NR);
  localparam int DIV_NW  = (RNUM_W > SUM_W) ? RNUM_W : SUM_W;
  localparam int DIV_DW  = WIN_W + DES_W;
  localparam int TOT_W   = Q_W + $clog2(NP);
  localparam int QMAX    = (1 << Q_W) - 1;

  // ---------------- classification and counting ----------------
  logic [NRJ*CNT_W-1:0] cnt_flat;
  logic [NRJ*CNT_W-1:0] snap_flat;
  seq_e                 state;
  logic                 accept;

  assign accept = window_done && (state == ST_IDLE);

  for (genvar p = 0; p < NP; p++) begin : g_par
    logic [1:0] rng;

    resid_classify #(.SAMP_W(SAMP_W)) cls_i (
      .sample (samples[p*SAMP_W +: SAMP_W]),
      .lo_thr (thr_lo[p*SAMP_W +: SAMP_W]),
      .hi_thr (thr_hi[p*SAMP_W +: SAMP_W]),
      .rng    (rng)
    );

    resid_bank #(.CNT_W(CNT_W)) bank_i (
      .clk    (clk),
      .rst    (rst),
      .inc    (sample_vld),
      .rng    (rng),
      .accept (accept),
      .cnt_o  (cnt_flat[p*NR*CNT_W +: NR*CNT_W]),
      .snap_o (snap_flat[p*NR*CNT_W +: NR*CNT_W])
    );
  end

  // ---------------- per-job operands ----------------
  logic [Q_W-1:0]    res_w   [NJ];
  logic              zf_w    [NRJ];
  logic [WIN_W-1:0]  win_len [NP];
  logic [SUM_W-1:0]  rsum    [NP];
  logic [DIV_NW-1:0] num_job [NJ];
  logic [DIV_DW-1:0] den_job [NJ];

  for (genvar p = 0; p < NP; p++) begin : g_sum
    always_comb begin
      win_len[p] = '0;
      rsum[p]    = '0;
      for (int r = 0; r < NR; r++) begin
        win_len[p] = win_len[p] + WIN_W'(snap_flat[(p*NR+r)*CNT_W +: CNT_W]);
        rsum[p]    = rsum[p] + SUM_W'(res_w[p*NR+r]);
      end
    end
    assign num_job[NRJ+p] = DIV_NW'(rsum[p]);
    assign den_job[NRJ+p] = DIV_DW'(NR);
  end

  for (genvar j = 0; j < NRJ; j++) begin : g_rjob
    assign num_job[j] = DIV_NW'(snap_flat[j*CNT_W +: CNT_W]) * DIV_NW'(SCALE);
    assign den_job[j] = DIV_DW'(win_len[j/NR]) * DIV_DW'(desired_pct[j*DES_W +: DES_W]);
  end

  // ---------------- sequencer ----------------
  logic [JB-1:0]     job;
  logic [DIV_NW-1:0] num_sel;
  logic [DIV_DW-1:0] den_sel;
  logic              den_zero;
  logic              div_start;
  logic              div_done;
  logic [DIV_NW-1:0] quo;
  logic              wr_en;
  logic              zero_now;
  logic [Q_W-1:0]    res_now;
  logic              last_job;

  assign num_sel   = num_job[job];
  assign den_sel   = den_job[job];
  assign den_zero  = (den_sel == '0);
  assign div_start = (state == ST_ISSUE) && !den_zero;
  assign zero_now  = (state == ST_ISSUE);
  assign wr_en     = ((state == ST_ISSUE) && den_zero) || ((state == ST_WAIT) && div_done);
  assign res_now   = zero_now ? '0 : ((quo > DIV_NW'(QMAX)) ? {Q_W{1'b1}} : quo[Q_W-1:0]);
  assign last_job  = (job == JB'(NJ - 1));

  resid_divider #(.NW(DIV_NW), .DW(DIV_DW)) div_i (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (num_sel),
    .den   (den_sel),
    .done  (div_done),
    .quo   (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      job   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (window_done) begin
            job   <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (state == ST_ISSUE && !den_zero) begin
            state <= ST_WAIT;
          end else if (wr_en) begin
            if (last_job) begin
              state <= ST_FINISH;
            end else begin
              job   <= job + JB'(1);
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar j = 0; j < NJ; j++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) res_w[j] <= '0;
      else if (wr_en && job == JB'(j)) res_w[j] <= res_now;
    end
  end

  for (genvar j = 0; j < NRJ; j++) begin : g_zf
    always_ff @(posedge clk) begin
      if (rst) zf_w[j] <= 1'b0;
      else if (wr_en && job == JB'(j)) zf_w[j] <= zero_now;
    end
  end

  // ---------------- registered result publication ----------------
  logic [TOT_W-1:0]           tot_sum;
  logic [NRJ*Q_W-1:0]         ratio_nx;
  logic [NRJ-1:0]             zf_nx;
  logic [NP*Q_W-1:0]          score_nx;

  always_comb begin
    tot_sum = '0;
    for (int p = 0; p < NP; p++) begin
      tot_sum            = tot_sum + TOT_W'(res_w[NRJ+p]);
      score_nx[p*Q_W +: Q_W] = res_w[NRJ+p];
    end
    for (int j = 0; j < NRJ; j++) begin
      ratio_nx[j*Q_W +: Q_W] = res_w[j];
      zf_nx[j]               = zf_w[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      ratio_o   <= '0;
      zero_flag <= '0;
      score_o   <= '0;
      total_o   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (state == ST_FINISH) begin
        res_valid <= 1'b1;
        ratio_o   <= ratio_nx;
        zero_flag <= zf_nx;
        score_o   <= score_nx;
        total_o   <= tot_sum;
      end
    end
  end
endmodule

// File: rtl/resid_score_chk.sv
module resid_score_chk #(
  parameter int NP    = 2,
  parameter int NR    = 3,
  parameter int Q_W   = 16,
  parameter int CNT_W = 16,
  parameter int TOT_W = 17
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  res_valid,
  input logic [NP*NR*Q_W-1:0]  ratio_o,
  input logic [NP*NR-1:0]      zero_flag,
  input logic [NP*Q_W-1:0]     score_o,
  input logic [TOT_W-1:0]      total_o,
  input logic                  accept,
  input logic [NP*NR*CNT_W-1:0] cnt_flat
);
  // R8: the ready strobe never lasts two cycles
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8: published results do not move between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(ratio_o) && $stable(score_o) && $stable(total_o) && $stable(zero_flag)));

  for (genvar j = 0; j < NP*NR; j++) begin : g_band
    // R3: a flagged band carries a zero score
    a_r3_flag_zero: assert property (@(posedge clk) disable iff (rst)
      zero_flag[j] |-> (ratio_o[j*Q_W +: Q_W] == '0));

    // R6: counts only grow inside a window (saturate, never wrap)
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
      !$past(accept) |-> (cnt_flat[j*CNT_W +: CNT_W] >= $past(cnt_flat[j*CNT_W +: CNT_W])));

    // R7: a closed window leaves the counts at zero
    a_r7_cleared: assert property (@(posedge clk) disable iff (rst)
      $past(accept) |-> (cnt_flat[j*CNT_W +: CNT_W] == '0));
  end

  for (genvar p = 0; p < NP; p++) begin : g_par
    // R5: the overall index is never below any single quantity score
    a_r5_total_bound: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (total_o >= TOT_W'(score_o[p*Q_W +: Q_W])));
  end
endmodule

bind resid_score_eval resid_score_chk #(
  .NP    (NP),
  .NR    (resid_pkg::NUM_RANGES),
  .Q_W   (Q_W),
  .CNT_W (CNT_W),
  .TOT_W (Q_W + $clog2(NP))
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .res_valid (res_valid),
  .ratio_o   (ratio_o),
  .zero_flag (zero_flag),
  .score_o   (score_o),
  .total_o   (total_o),
  .accept    (accept),
  .cnt_flat  (cnt_flat)
);

// File: tb/resid_score_eval_tb.sv
module resid_score_eval_tb_top;
  localparam int NP = 2;
  localparam int NR = 3;
  localparam int CW = 8;
  localparam int CMAX = 255;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sample_vld = 1'b0;
  logic [15:0]     samples = '0;
  logic [15:0]     thr_lo;
  logic [15:0]     thr_hi;
  logic [41:0]     desired_pct = '0;
  logic            window_done = 1'b0;
  logic            res_valid;
  logic [95:0]     ratio_o;
  logic [5:0]      zero_flag;
  logic [31:0]     score_o;
  logic [16:0]     total_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mc [NP][NR];
  int ec [NP][NR];
  int dz [NP*NR];
  int tlo [NP] = '{74, 4};
  int thi [NP] = '{78, 10};

  // rows: temp[3], freq[3], count[3], desired[6] (temp low,mid,high, freq low,mid,high)
  localparam int VEC [4][15] = '{
    '{80, 76, 60,  12, 6, 2,   20, 60, 20,  20, 60, 20, 20, 60, 20},
    '{73, 72, 79,  4, 3, 11,   10, 30, 40,  50, 25, 25, 10, 30, 60},
    '{78, 74, 100, 10, 0, 255, 33, 33, 34,  0, 50, 50, 30, 30, 40},
    '{0, 77, 90,   5, 9, 1,    1, 2, 97,    1, 1, 98, 5, 5, 90}
  };

  assign thr_lo = {8'(tlo[1]), 8'(tlo[0])};
  assign thr_hi = {8'(thi[1]), 8'(thi[0])};

  always #10 clk = ~clk;

  resid_score_eval #(.CNT_W(CW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .sample_vld  (sample_vld),
    .samples     (samples),
    .thr_lo      (thr_lo),
    .thr_hi      (thr_hi),
    .desired_pct (desired_pct),
    .window_done (window_done),
    .res_valid   (res_valid),
    .ratio_o     (ratio_o),
    .zero_flag   (zero_flag),
    .score_o     (score_o),
    .total_o     (total_o)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int band(int v, int lo, int hi);
    if (v > hi) return 2;
    if (v >= lo) return 1;
    return 0;
  endfunction

  task automatic set_des();
    for (int j = 0; j < NP*NR; j++) desired_pct[j*7 +: 7] = 7'(dz[j]);
  endtask

  task automatic model_clear();
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) mc[p][r] = 0;
  endtask

  task automatic model_add(int t, int f);
    int b0, b1;
    b0 = band(t, tlo[0], thi[0]);
    b1 = band(f, tlo[1], thi[1]);
    if (mc[0][b0] < CMAX) mc[0][b0]++;
    if (mc[1][b1] < CMAX) mc[1][b1]++;
  endtask

  task automatic feed(int t, int f, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_vld = 1'b1;
      samples = {8'(f), 8'(t)};
      model_add(t, f);
    end
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic snap_model();
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) ec[p][r] = mc[p][r];
    model_clear();
  endtask

  task automatic close_window();
    @(negedge clk);
    window_done = 1'b1;
    snap_model();
    @(negedge clk);
    window_done = 1'b0;
  endtask

  task automatic wait_valid(string req);
    int w = 0;
    while (!res_valid && w < 3000) begin
      @(negedge clk);
      w++;
    end
    check({req, " result strobe seen"}, res_valid, 1);
  endtask

  task automatic verify(string req);
    longint exp_r, win, sum, exp_s, exp_t;
    exp_t = 0;
    for (int p = 0; p < NP; p++) begin
      win = 0;
      sum = 0;
      for (int r = 0; r < NR; r++) win += ec[p][r];
      for (int r = 0; r < NR; r++) begin
        int j = p*NR + r;
        if (dz[j] == 0 || win == 0) exp_r = 0;
        else exp_r = (longint'(ec[p][r]) * 25600) / (win * dz[j]);
        sum += exp_r;
        check({req, " R2 band ratio"}, ratio_o[j*16 +: 16], exp_r);
        check({req, " R3 zero flag"}, zero_flag[j], (dz[j] == 0 || win == 0) ? 1 : 0);
      end
      exp_s = sum / 3;
      exp_t += exp_s;
      check({req, " R4 quantity score"}, score_o[p*16 +: 16], exp_s);
    end
    check({req, " R5 total"}, total_o, exp_t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 res_valid", res_valid, 0);
    check("R10 ratios", ratio_o, 0);
    check("R10 flags", zero_flag, 0);
    check("R10 scores", score_o, 0);
    check("R10 total", total_o, 0);

    // R1 R2 R4 R5 R11: vector table
    for (int v = 0; v < 4; v++) begin
      for (int j = 0; j < 6; j++) dz[j] = VEC[v][9+j];
      set_des();
      for (int s = 0; s < 3; s++) feed(VEC[v][s], VEC[v][3+s], VEC[v][6+s]);
      close_window();
      wait_valid("R1 R11 vector");
      verify("R1 R11 vector");
    end

    // R8: strobe lasts one cycle and outputs hold across new samples
    begin
      logic [95:0] held;
      held = ratio_o;
      @(negedge clk);
      check("R8 strobe width", res_valid, 0);
      feed(95, 15, 7);
      check("R8 ratios held", ratio_o, held);
    end
    model_clear();
    close_window();
    wait_valid("R8 drain");

    // R3: empty window
    close_window();
    wait_valid("R3 empty");
    verify("R3 empty window");

    // R6: saturation of counts
    dz = '{0, 50, 50, 20, 40, 40};
    set_des();
    feed(90, 6, 300);
    feed(76, 1, 10);
    close_window();
    wait_valid("R6");
    verify("R6 saturated counts");

    // R7: sample in the same cycle as window_done belongs to the closing window
    dz = '{20, 60, 20, 20, 60, 20};
    set_des();
    feed(60, 2, 4);
    @(negedge clk);
    sample_vld = 1'b1;
    samples = {8'd12, 8'd90};
    model_add(90, 12);
    window_done = 1'b1;
    snap_model();
    @(negedge clk);
    sample_vld = 1'b0;
    window_done = 1'b0;
    wait_valid("R7");
    verify("R7 same-cycle sample");

    // R9: close ignored while busy; samples before and after it stay in one window
    feed(76, 6, 6);
    close_window();
    repeat (3) @(negedge clk);
    @(negedge clk);
    window_done = 1'b1;
    @(negedge clk);
    window_done = 1'b0;
    feed(80, 12, 5);
    wait_valid("R9 first");
    verify("R9 first window");
    feed(60, 2, 5);
    close_window();
    wait_valid("R9 second");
    verify("R9 continued window");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule